// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Resolver

This block keeps a two-flag status word for each peripheral on an interrupt daisy chain. From those words it works out which device may raise the next interrupt to the CPU and which device is being serviced right now. Any device that is in service masks every request from a device below it in the chain. The block reports the winning requester and the deepest in-service device, each with its own valid bit, and drives a pending-interrupt level toward the CPU.

Peripheral logic writes a new status for one device at a time. A write only triggers a new evaluation when it actually changes the stored word. The CPU side pulses an acknowledge when it takes the interrupt, and that drops the current requester. A clear-all strobe empties the whole chain. All outputs are registered and take their new values on the same clock edge that stores the status.

Top module: `dc_daisy_resolver`

## Requirements
- R1: While reset is held and after it is released, every device status is zero and req_vld, svc_vld and int_pend are low.
- R2: A status word has the request flag in bit 0 and the in-service flag in bit 1. A write with upd_vld high stores upd_st for device upd_idx.
- R3: The requester is the device with the highest index whose request flag is set, provided no device at a strictly higher index has its in-service flag set. A device with both flags set may still be the requester.
- R4: svc_vld is high and svc_idx names the highest-index device with its in-service flag set, whenever such a device exists after an evaluation.
- R5: A status-changing write updates req_vld, req_idx, svc_vld, svc_idx and int_pend on the same clock edge that stores the status.
- R6: A write whose value equals the stored status triggers no evaluation. All outputs keep their values, including a requester that was already dropped by an acknowledge.
- R7: An ack pulse drops req_vld and int_pend on the next edge. The in-service outputs and the stored statuses stay unchanged.
- R8: int_pend is high exactly when req_vld is high.
- R9: clr_all zeroes every status and drops req_vld, svc_vld and int_pend on the next edge. It takes priority over a write and an ack in the same cycle.
- R10: When a status-changing write and an ack fall in the same cycle, the outputs take the result of the new evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_vld | input | 1 | Status write strobe |
| upd_idx | input | IDX_W | Device addressed by the write |
| upd_st | input | 2 | New status: bit 0 request, bit 1 in service |
| clr_all | input | 1 | Clear every device status |
| ack | input | 1 | CPU acknowledge, consumes the requester |
| req_vld | output | 1 | A requester exists |
| req_idx | output | IDX_W | Winning requester index |
| svc_vld | output | 1 | A device is in service |
| svc_idx | output | IDX_W | Highest in-service device index |
| int_pend | output | 1 | Interrupt pending level to the CPU |

## Verification
The bench stacks in-service devices above and below requesters. A resolver with reversed masking would then report a device that the chain should hide, or lose the one that should win. It rewrites an unchanged status after an acknowledge, because a design that evaluates on every write would wrongly bring the consumed request back. It also drives an acknowledge together with a changing write, and clear-all together with a write. A design with the wrong ordering would lose the new requester in the first case and leave a stale in-service device that masks later requests in the second.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef struct packed {
    logic in_svc;
    logic req;
  } dev_stat_t;
endpackage

// File: rtl/dc_status_bank.sv
module dc_status_bank
  import dc_pkg::*;
#(
  parameter int N_DEV = 8,
  parameter int IDX_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_vld,
  input  logic [IDX_W-1:0]      upd_idx,
  input  dev_stat_t             upd_st,
  input  logic                  clr_all,
  output dev_stat_t [N_DEV-1:0] st_view,
  output logic                  stat_chg
);
  dev_stat_t [N_DEV-1:0] st_q;
  dev_stat_t [N_DEV-1:0] st_d;
  logic                  st_en;
  logic                  idx_ok;

  assign idx_ok = (32'(upd_idx) < N_DEV);

  always_comb begin
    stat_chg = 1'b0;
    if (upd_vld && idx_ok && !clr_all)
      stat_chg = (st_q[upd_idx] != upd_st);
  end

  always_comb begin
    st_d = st_q;
    if (clr_all)
      st_d = '0;
    else if (stat_chg)
      st_d[upd_idx] = upd_st;
  end

  assign st_en   = clr_all | stat_chg;
  assign st_view = st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= '0;
    else if (st_en)
      st_q <= st_d;
  end
endmodule

// File: rtl/dc_chain_eval.sv
module dc_chain_eval
  import dc_pkg::*;
#(
  parameter int N_DEV = 8,
  parameter int IDX_W = 3
) (
  input  dev_stat_t [N_DEV-1:0] st,
  output logic                  req_vld,
  output logic [IDX_W-1:0]      req_idx,
  output logic                  svc_vld,
  output logic [IDX_W-1:0]      svc_idx
);
  always_comb begin
    req_vld = 1'b0;
    req_idx = '0;
    svc_vld = 1'b0;
    svc_idx = '0;
    for (int d = 0; d < N_DEV; d++) begin
      if (st[d].in_svc) begin
        req_vld = 1'b0;
        req_idx = '0;
        svc_vld = 1'b1;
        svc_idx = IDX_W'(d);
      end
      if (st[d].req) begin
        req_vld = 1'b1;
        req_idx = IDX_W'(d);
      end
    end
  end
endmodule

// File: rtl/dc_daisy_resolver.sv
module dc_daisy_resolver
  import dc_pkg::*;
#(
  parameter int N_DEV = 8,
  localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_vld,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [1:0]       upd_st,
  input  logic             clr_all,
  input  logic             ack,
  output logic             req_vld,
  output logic [IDX_W-1:0] req_idx,
  output logic             svc_vld,
  output logic [IDX_W-1:0] svc_idx,
  output logic             int_pend
);
  dev_stat_t [N_DEV-1:0] st_view;
  logic                  stat_chg;
  logic                  ev_req_vld, ev_svc_vld;
  logic [IDX_W-1:0]      ev_req_idx, ev_svc_idx;

  logic                  req_vld_d, svc_vld_d, pend_d, out_en;
  logic [IDX_W-1:0]      req_idx_d, svc_idx_d;

  dc_status_bank #(.N_DEV(N_DEV), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_vld  (upd_vld),
    .upd_idx  (upd_idx),
    .upd_st   (dev_stat_t'(upd_st)),
    .clr_all  (clr_all),
    .st_view  (st_view),
    .stat_chg (stat_chg)
  );

  dc_chain_eval #(.N_DEV(N_DEV), .IDX_W(IDX_W)) u_eval (
    .st      (st_view),
    .req_vld (ev_req_vld),
    .req_idx (ev_req_idx),
    .svc_vld (ev_svc_vld),
    .svc_idx (ev_svc_idx)
  );

  always_comb begin
    req_vld_d = req_vld;
    req_idx_d = req_idx;
    svc_vld_d = svc_vld;
    svc_idx_d = svc_idx;
    if (clr_all) begin
      req_vld_d = 1'b0;
      req_idx_d = '0;
      svc_vld_d = 1'b0;
      svc_idx_d = '0;
    end else if (stat_chg) begin
      req_vld_d = ev_req_vld;
      req_idx_d = ev_req_idx;
      svc_vld_d = ev_svc_vld;
      svc_idx_d = ev_svc_idx;
    end else if (ack) begin
      req_vld_d = 1'b0;
      req_idx_d = '0;
    end
    pend_d = req_vld_d;
  end

  assign out_en = clr_all | stat_chg | ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_vld  <= 1'b0;
      req_idx  <= '0;
      svc_vld  <= 1'b0;
      svc_idx  <= '0;
      int_pend <= 1'b0;
    end else if (out_en) begin
      req_vld  <= req_vld_d;
      req_idx  <= req_idx_d;
      svc_vld  <= svc_vld_d;
      svc_idx  <= svc_idx_d;
      int_pend <= pend_d;
    end
  end
endmodule

// File: rtl/dc_daisy_chk.sv
module dc_daisy_chk #(
  parameter int N_DEV = 8,
  localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_all,
  input logic             ack,
  input logic             stat_chg,
  input logic             req_vld,
  input logic [IDX_W-1:0] req_idx,
  input logic             svc_vld,
  input logic [IDX_W-1:0] svc_idx,
  input logic             int_pend
);
  // R3: no requester below the in-service device
  a_r3_req_not_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && svc_vld) |-> (req_idx >= svc_idx));

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (!req_vld && !svc_vld && !int_pend));

  a_r7_ack_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !clr_all && !stat_chg) |=>
      (!req_vld && !int_pend && $stable(svc_vld) && $stable(svc_idx)));

  a_r6_hold_without_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_all && !stat_chg && !ack) |=>
      ($stable(req_vld) && $stable(req_idx) && $stable(svc_vld) && $stable(svc_idx)));

  a_r8_pend_tracks_req: assert property (@(posedge clk) disable iff (!rst_n)
    int_pend == req_vld);
endmodule

bind dc_daisy_resolver dc_daisy_chk #(.N_DEV(N_DEV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_all  (clr_all),
  .ack      (ack),
  .stat_chg (stat_chg),
  .req_vld  (req_vld),
  .req_idx  (req_idx),
  .svc_vld  (svc_vld),
  .svc_idx  (svc_idx),
  .int_pend (int_pend)
);

// File: tb/sim_dc_daisy_resolver.sv
module sim_dc_daisy_resolver;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_vld = 1'b0, clr_all = 1'b0, ack = 1'b0;
  logic [IW-1:0] upd_idx = '0;
  logic [1:0] upd_st = '0;
  logic req_vld, svc_vld, int_pend;
  logic [IW-1:0] req_idx, svc_idx;

  always #2 clk = ~clk;

  dc_daisy_resolver #(.N_DEV(N)) u0 (
    .clk(clk), .rst_n(rst_n), .upd_vld(upd_vld), .upd_idx(upd_idx),
    .upd_st(upd_st), .clr_all(clr_all), .ack(ack),
    .req_vld(req_vld), .req_idx(req_idx), .svc_vld(svc_vld),
    .svc_idx(svc_idx), .int_pend(int_pend)
  );

  typedef struct {
    int    due;
    logic  rv;
    int    ri;
    logic  sv;
    int    si;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [1:0] m_st[N];
  logic m_rv = 1'b0, m_sv = 1'b0;
  int m_ri = 0, m_si = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare due items one cycle after they were driven
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (req_vld !== e.rv || int_pend !== e.rv || svc_vld !== e.sv ||
          (e.rv && int'(req_idx) != e.ri) || (e.sv && int'(svc_idx) != e.si)) begin
        n_bad++;
        $display("FAIL %s: got rv=%b ri=%0d sv=%b si=%0d pend=%b, expected rv=%b ri=%0d sv=%b si=%0d pend=%b",
                 e.tag, req_vld, req_idx, svc_vld, svc_idx, int_pend,
                 e.rv, e.ri, e.sv, e.si, e.rv);
      end
    end
  end

  function automatic void model_eval();
    m_rv = 1'b0; m_sv = 1'b0; m_ri = 0; m_si = 0;
    for (int d = 0; d < N; d++) begin
      if (m_st[d][1]) begin m_rv = 1'b0; m_sv = 1'b1; m_si = d; end
      if (m_st[d][0]) begin m_rv = 1'b1; m_ri = d; end
    end
  endfunction

  task automatic op(input logic c, input logic u, input int idx,
                    input logic [1:0] s, input logic a, input string tag);
    exp_t e;
    @(negedge clk);
    clr_all = c; upd_vld = u; upd_idx = IW'(idx); upd_st = s; ack = a;
    if (c) begin
      for (int d = 0; d < N; d++) m_st[d] = 2'b00;
      m_rv = 1'b0; m_sv = 1'b0;
    end else if (u && m_st[idx] != s) begin
      m_st[idx] = s;
      model_eval();
    end else if (a) begin
      m_rv = 1'b0;
    end
    e.due = cyc + 1; e.rv = m_rv; e.ri = m_ri; e.sv = m_sv; e.si = m_si; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    #1;
    clr_all = 1'b0; upd_vld = 1'b0; ack = 1'b0;
  endtask

  initial begin
    for (int d = 0; d < N; d++) m_st[d] = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (req_vld !== 1'b0 || svc_vld !== 1'b0 || int_pend !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: in reset rv=%b sv=%b pend=%b, expected 0 0 0", req_vld, svc_vld, int_pend);
    end
    @(negedge clk); rst_n = 1'b1;
    op(0, 0, 0, 2'b00, 0, "R1 idle after reset");
    op(0, 1, 2, 2'b01, 0, "R2 R5 request dev2");
    op(0, 1, 5, 2'b01, 0, "R3 higher requester dev5");
    op(0, 1, 6, 2'b10, 0, "R4 dev6 in service masks below");
    op(0, 1, 7, 2'b01, 0, "R3 dev7 above service");
    op(0, 0, 0, 2'b00, 1, "R7 ack drops requester");
    op(0, 1, 7, 2'b01, 0, "R6 same status no revive");
    op(0, 1, 7, 2'b00, 0, "R3 dev7 withdrawn, rest masked");
    op(0, 1, 6, 2'b00, 0, "R4 dev6 leaves service");
    op(0, 1, 3, 2'b11, 0, "R3 dev3 both flags");
    op(0, 1, 5, 2'b00, 0, "R3 dev3 requester and in service");
    op(0, 1, 0, 2'b01, 1, "R10 ack with changing write");
    op(0, 1, 1, 2'b10, 0, "R4 lower service keeps highest");
    op(0, 0, 0, 2'b00, 1, "R7 ack keeps service");
    op(1, 1, 4, 2'b01, 1, "R9 clear beats write and ack");
    op(0, 1, 1, 2'b01, 0, "R9 statuses were zeroed");
    op(0, 1, 1, 2'b00, 0, "R8 pend follows withdrawn request");
    for (int d = 0; d < N; d++) begin
      op(0, 1, d, 2'b01, 0, "R3 walking requester");
      op(0, 1, d, 2'b00, 0, "R3 walking requester off");
    end
    op(0, 0, 0, 2'b00, 0, "R6 idle hold");
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule